// File: doc/BRIEF.md
# Locked Configuration Register Window

This block is the device-side register interface of a multi-function I/O controller. The host reaches it through a window of two byte addresses. Offset 0 holds the register index and offset 1 carries the data of the indexed register. After reset the window is locked. It opens only after a fixed sequence of key bytes has been written to offset 0. The bytes of that sequence depend on the selected key style and, for one style, on which of two base addresses the window decodes at.

When the window is open, indexes below 0x30 form a small global area. That area holds the device-select register and the read-only chip identity. Indexes 0x30 and above are banked: the device-select register picks which logical device's enable, base-address, IRQ and DMA registers they reach. Every implemented device drives its enable bit, its first base address and its IRQ byte out of the block on flat vectors, where the functions it serves can use them. Each key style has its own command that locks the window again.

Top module: `cfgport_top`

## Requirements
- R1: When the window is open, a write to offset 0 loads the register index and a read of offset 0 returns it. A read or write at offset 1 reaches the register the index selects. Read data is valid in the same cycle that io_rd is high, and io_rdata is 0x00 when io_rd is low.
- R2: When the window is locked, a read of either offset returns 0xFF. Writes to offset 1 change no register and no output. A byte written to offset 0 goes only to the key matcher and does not load the index.
- R3: With KEY_KIND = KEY_A, the window opens after 0x87, 0x01, 0x55 and a fourth byte are written to offset 0 in that order. The fourth byte is 0x55 when HI_WINDOW = 0 (window at 0x2E) and 0xAA when HI_WINDOW = 1 (window at 0x4E). Any other fourth byte leaves the window locked.
- R4: With KEY_KIND = KEY_B, the window opens after 0x87 is written to offset 0 on two writes in a row.
- R5: A byte that does not match the next expected key byte restarts the matcher. If that byte is 0x87, it counts as the first byte of a new attempt.
- R6: With KEY_A, writing 0x02 to register 0x02 locks the window, and any other value written there does not. With KEY_B, writing 0xAA to offset 0 while open locks the window. Locking sets the index to 0x00 and keeps the device select.
- R7: Global register 0x20 reads CHIP_ID[15:8] and 0x21 reads CHIP_ID[7:0]. Register 0x22 reads REV_ID with KEY_A and 0x00 with KEY_B. These three registers ignore writes.
- R8: Register 0x07 is the read/write device select. Registers 0x00 to 0x06 and the global indexes that are not used store nothing and read 0x00.
- R9: For the selected device, 0x30 bit 0 is the enable (read back as {7'b0, en}). 0x60/0x61 hold the first base address and 0x62/0x63 the second, high byte first. 0x70 is the IRQ byte and 0x74 the DMA byte. Other banked indexes read 0x00.
- R10: When the device select is NUM_DEV or higher, banked writes are dropped and banked reads return 0x00.
- R11: After reset the window is locked, the index and device select are 0, and every device register is 0.
- R12: dev_en[i], dev_base[16*i +: 16] and dev_irq[8*i +: 8] carry device i's enable, first base address and IRQ byte. They change on the rising edge that follows the data write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_wr | input | 1 | Write strobe for one byte, one cycle long |
| io_rd | input | 1 | Read strobe |
| io_addr | input | 1 | Window offset: 0 index, 1 data |
| io_wdata | input | 8 | Write byte |
| io_rdata | output | 8 | Read byte, combinational |
| cfg_open | output | 1 | High while the window is unlocked |
| dev_en | output | NUM_DEV | Enable bit for each device |
| dev_base | output | NUM_DEV*16 | First base address for each device |
| dev_irq | output | NUM_DEV*8 | IRQ byte for each device |

## Verification
Read data comes from a combinational path, so it is valid in the same cycle as the strobe. The bench raises io_rd at a falling edge and samples io_rdata 1 ns later. Every write, whether a key byte, an exit command, an index load or a register store, takes effect on the next rising edge. The bench drives a write for one full cycle starting at a falling edge, so cfg_open, the device vectors and any read that follows are sampled at the next falling edge, after that one register stage. Random banked traffic on the default instance is compared with a register model kept in the bench. Directed sequences on two other instances cover the other key styles and the wrong-byte restarts.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;

    typedef enum logic {
        KEY_A = 1'b0,
        KEY_B = 1'b1
    } key_kind_e;

    localparam logic [7:0] IDX_EXIT_A = 8'h02;
    localparam logic [7:0] IDX_LDN    = 8'h07;
    localparam logic [7:0] IDX_ID_HI  = 8'h20;
    localparam logic [7:0] IDX_ID_LO  = 8'h21;
    localparam logic [7:0] IDX_REV    = 8'h22;
    localparam logic [7:0] IDX_BANK   = 8'h30;
    localparam logic [7:0] IDX_EN     = 8'h30;
    localparam logic [7:0] IDX_B0_HI  = 8'h60;
    localparam logic [7:0] IDX_B0_LO  = 8'h61;
    localparam logic [7:0] IDX_B1_HI  = 8'h62;
    localparam logic [7:0] IDX_B1_LO  = 8'h63;
    localparam logic [7:0] IDX_IRQ    = 8'h70;
    localparam logic [7:0] IDX_DMA    = 8'h74;

    localparam logic [7:0] KEY_LEAD   = 8'h87;
    localparam logic [7:0] EXIT_VAL_A = 8'h02;
    localparam logic [7:0] EXIT_KEY_B = 8'hAA;

    typedef struct packed {
        logic        en;
        logic [15:0] base0;
        logic [15:0] base1;
        logic [7:0]  irq;
        logic [7:0]  dma;
    } ldev_regs_t;

    function automatic int key_len(key_kind_e kind);
        return (kind == KEY_A) ? 4 : 2;
    endfunction

    // Expected key byte at position pos of the unlock sequence.
    function automatic logic [7:0] key_byte(key_kind_e kind, logic hi_window,
                                            int unsigned pos);
        if (kind == KEY_B) return KEY_LEAD;
        case (pos)
            0:       return KEY_LEAD;
            1:       return 8'h01;
            2:       return 8'h55;
            default: return hi_window ? 8'hAA : 8'h55;
        endcase
    endfunction

    function automatic logic [7:0] ldev_read(ldev_regs_t r, logic [7:0] idx);
        case (idx)
            IDX_EN:    return {7'b0, r.en};
            IDX_B0_HI: return r.base0[15:8];
            IDX_B0_LO: return r.base0[7:0];
            IDX_B1_HI: return r.base1[15:8];
            IDX_B1_LO: return r.base1[7:0];
            IDX_IRQ:   return r.irq;
            IDX_DMA:   return r.dma;
            default:   return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/cfgport_key_lock.sv
module cfgport_key_lock
    import cfgport_pkg::*;
#(
    parameter key_kind_e KIND      = KEY_A,
    parameter bit        HI_WINDOW = 1'b0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       key_wr,
    input  logic [7:0] key_in,
    input  logic       exit_req,
    output logic       open
);
    localparam int LEN = key_len(KIND);
    localparam int PW  = $clog2(LEN + 1);

    logic [PW-1:0] pos_q;
    logic [7:0]    want;

    assign want = key_byte(KIND, HI_WINDOW, 32'(pos_q));

    always_ff @(posedge clk) begin
        if (rst) begin
            open  <= 1'b0;
            pos_q <= '0;
        end else if (open) begin
            if (exit_req) begin
                open  <= 1'b0;
                pos_q <= '0;
            end
        end else if (key_wr) begin
            if (key_in == want) begin
                if (pos_q == PW'(LEN - 1)) begin
                    open  <= 1'b1;
                    pos_q <= '0;
                end else begin
                    pos_q <= pos_q + PW'(1);
                end
            end else if (key_in == KEY_LEAD) begin
                pos_q <= PW'(1);
            end else begin
                pos_q <= '0;
            end
        end
    end
endmodule

// File: rtl/cfgport_ldev_regs.sv
module cfgport_ldev_regs
    import cfgport_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       we,
    input  logic [7:0] idx,
    input  logic [7:0] wdata,
    output ldev_regs_t regs
);
    always_ff @(posedge clk) begin
        if (rst) begin
            regs <= '0;
        end else if (we) begin
            case (idx)
                IDX_EN:    regs.en          <= wdata[0];
                IDX_B0_HI: regs.base0[15:8] <= wdata;
                IDX_B0_LO: regs.base0[7:0]  <= wdata;
                IDX_B1_HI: regs.base1[15:8] <= wdata;
                IDX_B1_LO: regs.base1[7:0]  <= wdata;
                IDX_IRQ:   regs.irq         <= wdata;
                IDX_DMA:   regs.dma         <= wdata;
                default:   ;
            endcase
        end
    end
endmodule

// File: rtl/cfgport_top.sv
module cfgport_top
    import cfgport_pkg::*;
#(
    parameter key_kind_e   KEY_KIND  = KEY_A,
    parameter bit          HI_WINDOW = 1'b0,
    parameter int          NUM_DEV   = 4,
    parameter logic [15:0] CHIP_ID   = 16'h8721,
    parameter logic [7:0]  REV_ID    = 8'h05
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   io_wr,
    input  logic                   io_rd,
    input  logic                   io_addr,
    input  logic [7:0]             io_wdata,
    output logic [7:0]             io_rdata,
    output logic                   cfg_open,
    output logic [NUM_DEV-1:0]     dev_en,
    output logic [NUM_DEV*16-1:0]  dev_base,
    output logic [NUM_DEV*8-1:0]   dev_irq
);
    localparam int SEL_W = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1;

    logic [7:0]       idx_q;
    logic [7:0]       ldn_q;
    logic             idx_wr, dat_wr, exit_req, ldn_ok;
    logic [SEL_W-1:0] sel;
    logic [7:0]       rd_val;
    ldev_regs_t       dev_regs [NUM_DEV];

    assign idx_wr = io_wr & ~io_addr;
    assign dat_wr = io_wr &  io_addr;
    assign ldn_ok = (ldn_q < 8'(NUM_DEV));
    assign sel    = ldn_q[SEL_W-1:0];

    generate
        if (KEY_KIND == KEY_A) begin : g_exit_a
            assign exit_req = cfg_open && dat_wr && (idx_q == IDX_EXIT_A)
                              && (io_wdata == EXIT_VAL_A);
        end else begin : g_exit_b
            assign exit_req = cfg_open && idx_wr && (io_wdata == EXIT_KEY_B);
        end
    endgenerate

    cfgport_key_lock #(.KIND(KEY_KIND), .HI_WINDOW(HI_WINDOW)) u_lock (
        .clk      (clk),
        .rst      (rst),
        .key_wr   (idx_wr),
        .key_in   (io_wdata),
        .exit_req (exit_req),
        .open     (cfg_open)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q <= 8'h00;
            ldn_q <= 8'h00;
        end else if (exit_req) begin
            idx_q <= 8'h00;
        end else if (cfg_open && idx_wr) begin
            idx_q <= io_wdata;
        end else if (cfg_open && dat_wr && (idx_q == IDX_LDN)) begin
            ldn_q <= io_wdata;
        end
    end

    generate
        for (genvar i = 0; i < NUM_DEV; i++) begin : g_dev
            logic we_i;
            assign we_i = cfg_open && dat_wr && (idx_q >= IDX_BANK)
                          && (ldn_q == 8'(i));
            cfgport_ldev_regs u_regs (
                .clk   (clk),
                .rst   (rst),
                .we    (we_i),
                .idx   (idx_q),
                .wdata (io_wdata),
                .regs  (dev_regs[i])
            );
            assign dev_en[i]            = dev_regs[i].en;
            assign dev_base[16*i +: 16] = dev_regs[i].base0;
            assign dev_irq[8*i +: 8]    = dev_regs[i].irq;
        end
    endgenerate

    always_comb begin
        rd_val = 8'hFF;
        if (cfg_open) begin
            if (!io_addr) begin
                rd_val = idx_q;
            end else if (idx_q >= IDX_BANK) begin
                rd_val = ldn_ok ? ldev_read(dev_regs[sel], idx_q) : 8'h00;
            end else begin
                case (idx_q)
                    IDX_LDN:   rd_val = ldn_q;
                    IDX_ID_HI: rd_val = CHIP_ID[15:8];
                    IDX_ID_LO: rd_val = CHIP_ID[7:0];
                    IDX_REV:   rd_val = (KEY_KIND == KEY_A) ? REV_ID : 8'h00;
                    default:   rd_val = 8'h00;
                endcase
            end
        end
    end

    assign io_rdata = io_rd ? rd_val : 8'h00;
endmodule

// File: rtl/cfgport_chk.sv
module cfgport_chk #(
    parameter int          NUM_DEV = 4,
    parameter logic [15:0] CHIP_ID = 16'h8721
) (
    input logic               clk,
    input logic               rst,
    input logic               io_wr,
    input logic               io_rd,
    input logic               io_addr,
    input logic [7:0]         io_rdata,
    input logic               cfg_open,
    input logic [NUM_DEV-1:0] dev_en,
    input logic [7:0]         idx_q,
    input logic [7:0]         ldn_q
);
    // R2
    locked_read_ff_chk: assert property (@(posedge clk) disable iff (rst)
        (!cfg_open && io_rd) |-> (io_rdata == 8'hFF));

    // R2
    locked_en_stable_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(cfg_open) |-> $stable(dev_en));

    // R3
    unlock_by_index_write_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(cfg_open) |-> $past(io_wr && !io_addr));

    // R6
    lock_by_write_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(cfg_open) |-> $past(io_wr));

    // R7
    chip_id_hi_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_open && io_rd && io_addr && idx_q == 8'h20) |-> (io_rdata == CHIP_ID[15:8]));

    // R10
    absent_dev_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_open && io_rd && io_addr && idx_q >= 8'h30 && ldn_q >= 8'(NUM_DEV))
        |-> (io_rdata == 8'h00));

    // R11
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!cfg_open && idx_q == 8'h00 && ldn_q == 8'h00));
endmodule

bind cfgport_top cfgport_chk #(.NUM_DEV(NUM_DEV), .CHIP_ID(CHIP_ID)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .io_wr    (io_wr),
    .io_rd    (io_rd),
    .io_addr  (io_addr),
    .io_rdata (io_rdata),
    .cfg_open (cfg_open),
    .dev_en   (dev_en),
    .idx_q    (idx_q),
    .ldn_q    (ldn_q)
);

// File: tb/cfgport_top_bench.sv
module cfgport_top_bench;
    import cfgport_pkg::*;

    localparam int ND = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  wr_v = '0;
    logic        rd_s = 1'b0;
    logic        addr = 1'b0;
    logic [7:0]  wdata = 8'h00;
    logic [7:0]  rd_v [3];
    logic [2:0]  open_v;
    logic [ND-1:0]    en0, en1, en2;
    logic [ND*16-1:0] base0, base1, base2;
    logic [ND*8-1:0]  irq0, irq1, irq2;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    cfgport_top u_cfgport_top (
        .clk(clk), .rst(rst), .io_wr(wr_v[0]), .io_rd(rd_s), .io_addr(addr),
        .io_wdata(wdata), .io_rdata(rd_v[0]), .cfg_open(open_v[0]),
        .dev_en(en0), .dev_base(base0), .dev_irq(irq0));

    cfgport_top #(.HI_WINDOW(1'b1)) u_cfgport_top_hi (
        .clk(clk), .rst(rst), .io_wr(wr_v[1]), .io_rd(rd_s), .io_addr(addr),
        .io_wdata(wdata), .io_rdata(rd_v[1]), .cfg_open(open_v[1]),
        .dev_en(en1), .dev_base(base1), .dev_irq(irq1));

    cfgport_top #(.KEY_KIND(KEY_B), .CHIP_ID(16'hC452)) u_cfgport_top_b (
        .clk(clk), .rst(rst), .io_wr(wr_v[2]), .io_rd(rd_s), .io_addr(addr),
        .io_wdata(wdata), .io_rdata(rd_v[2]), .cfg_open(open_v[2]),
        .dev_en(en2), .dev_base(base2), .dev_irq(irq2));

    logic        m_en  [6];
    logic [15:0] m_b0  [6];
    logic [15:0] m_b1  [6];
    logic [7:0]  m_irq [6];
    logic [7:0]  m_dma [6];

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int s, input logic a, input logic [7:0] d);
        @(negedge clk);
        wr_v[s] = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_v[s] = 1'b0;
    endtask

    task automatic rd(input int s, input logic a, output logic [7:0] d);
        @(negedge clk);
        rd_s = 1'b1; addr = a;
        #1 d = rd_v[s];
        @(negedge clk);
        rd_s = 1'b0;
    endtask

    task automatic rd_reg(input int s, input logic [7:0] idx, output logic [7:0] d);
        wr(s, 1'b0, idx);
        rd(s, 1'b1, d);
    endtask

    function automatic logic [7:0] exp_bank(input int l, input logic [7:0] r);
        if (l >= ND) return 8'h00;
        case (r)
            8'h30: return {7'b0, m_en[l]};
            8'h60: return m_b0[l][15:8];
            8'h61: return m_b0[l][7:0];
            8'h62: return m_b1[l][15:8];
            8'h63: return m_b1[l][7:0];
            8'h70: return m_irq[l];
            8'h74: return m_dma[l];
            default: return 8'h00;
        endcase
    endfunction

    task automatic model_write(input int l, input logic [7:0] r, input logic [7:0] v);
        if (l < ND) begin
            case (r)
                8'h30: m_en[l] = v[0];
                8'h60: m_b0[l][15:8] = v;
                8'h61: m_b0[l][7:0] = v;
                8'h62: m_b1[l][15:8] = v;
                8'h63: m_b1[l][7:0] = v;
                8'h70: m_irq[l] = v;
                8'h74: m_dma[l] = v;
                default: ;
            endcase
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] d;
        logic [7:0] idx_set [8];
        int unsigned seed_init;
        seed_init = $urandom(32'h00C0FFEE);
        idx_set = '{8'h30, 8'h60, 8'h61, 8'h62, 8'h63, 8'h70, 8'h74, 8'h50};
        for (int k = 0; k < 6; k++) begin
            m_en[k] = 1'b0; m_b0[k] = '0; m_b1[k] = '0; m_irq[k] = '0; m_dma[k] = '0;
        end

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R11 reset state
        chk("R11 locked after reset", {29'b0, open_v}, 32'h0);
        chk("R11 enables clear", {28'b0, en0}, 32'h0);
        rd(0, 1'b1, d);  chk("R2 locked data read", d, 8'hFF);
        rd(0, 1'b0, d);  chk("R2 locked index read", d, 8'hFF);

        // R2 locked writes do nothing
        wr(0, 1'b0, 8'h30);
        wr(0, 1'b1, 8'h01);
        chk("R2 locked data write no enable", {28'b0, en0}, 32'h0);

        // R3 / R5 wrong fourth byte on low window, then restart on lead byte
        wr(0, 1'b0, 8'h87); wr(0, 1'b0, 8'h01); wr(0, 1'b0, 8'h55); wr(0, 1'b0, 8'hAA);
        chk("R3 wrong fourth byte stays locked", open_v[0], 1'b0);
        wr(0, 1'b0, 8'h87); wr(0, 1'b0, 8'h01); wr(0, 1'b0, 8'h87);
        wr(0, 1'b0, 8'h01); wr(0, 1'b0, 8'h55); wr(0, 1'b0, 8'h55);
        chk("R5 lead byte restarts match", open_v[0], 1'b1);
        rd(0, 1'b0, d);  chk("R2 locked index write not loaded", d, 8'h00);
        rd_reg(0, 8'h30, d); chk("R2 locked data write not stored", d, 8'h00);

        // R3 high window wants 0xAA
        wr(1, 1'b0, 8'h87); wr(1, 1'b0, 8'h01); wr(1, 1'b0, 8'h55); wr(1, 1'b0, 8'h55);
        chk("R3 high window rejects 0x55", open_v[1], 1'b0);
        wr(1, 1'b0, 8'h87); wr(1, 1'b0, 8'h01); wr(1, 1'b0, 8'h55); wr(1, 1'b0, 8'hAA);
        chk("R3 high window opens on 0xAA", open_v[1], 1'b1);

        // R4 / R5 double lead key
        wr(2, 1'b0, 8'h87); wr(2, 1'b0, 8'h00); wr(2, 1'b0, 8'h87);
        chk("R5 broken pair stays locked", open_v[2], 1'b0);
        wr(2, 1'b0, 8'h87);
        chk("R4 second lead opens", open_v[2], 1'b1);

        // R7 identity
        rd_reg(0, 8'h20, d); chk("R7 id high", d, 8'h87);
        rd_reg(0, 8'h21, d); chk("R7 id low", d, 8'h21);
        rd_reg(0, 8'h22, d); chk("R7 revision", d, 8'h05);
        wr(0, 1'b1, 8'h3C);  rd(0, 1'b1, d); chk("R7 revision ignores write", d, 8'h05);
        rd_reg(2, 8'h20, d); chk("R7 id high style B", d, 8'hC4);
        rd_reg(2, 8'h22, d); chk("R7 no revision style B", d, 8'h00);

        // R8 global area
        wr(0, 1'b0, 8'h05); wr(0, 1'b1, 8'h5A); rd(0, 1'b1, d);
        chk("R8 low index stores nothing", d, 8'h00);
        wr(0, 1'b0, 8'h07); wr(0, 1'b1, 8'h02); rd(0, 1'b1, d);
        chk("R8 device select readback", d, 8'h02);
        wr(0, 1'b1, 8'h00);

        // R9 enable width and unused banked index
        wr(0, 1'b0, 8'h30); wr(0, 1'b1, 8'hFE); rd(0, 1'b1, d);
        chk("R9 enable bit 0 only clear", d, 8'h00);
        wr(0, 1'b1, 8'hFF); rd(0, 1'b1, d);
        chk("R9 enable reads one", d, 8'h01);
        chk("R12 dev_en follows", {28'b0, en0}, 32'h1);
        m_en[0] = 1'b1;

        // R6 style A exit: wrong value keeps open, 0x02 locks
        wr(0, 1'b0, 8'h02); wr(0, 1'b1, 8'h01);
        chk("R6 other value keeps open", open_v[0], 1'b1);
        wr(0, 1'b1, 8'h02);
        chk("R6 exit command locks", open_v[0], 1'b0);
        rd(0, 1'b1, d); chk("R6 locked after exit reads FF", d, 8'hFF);
        wr(0, 1'b0, 8'h87); wr(0, 1'b0, 8'h01); wr(0, 1'b0, 8'h55); wr(0, 1'b0, 8'h55);
        rd(0, 1'b0, d); chk("R6 index cleared by exit", d, 8'h00);
        chk("R12 enable kept across lock", {28'b0, en0}, 32'h1);

        // R6 style B exit
        wr(2, 1'b0, 8'hAA);
        chk("R6 style B exit locks", open_v[2], 1'b0);

        // R1 R9 R10 R12 random banked traffic against the model
        for (int it = 0; it < 300; it++) begin
            int l;
            logic [7:0] r, v;
            l = $urandom_range(0, 5);
            r = idx_set[$urandom_range(0, 7)];
            v = 8'($urandom);
            wr(0, 1'b0, 8'h07); wr(0, 1'b1, 8'(l));
            wr(0, 1'b0, r);
            rd(0, 1'b0, d); chk("R1 index readback", d, r);
            wr(0, 1'b1, v);
            model_write(l, r, v);
            rd(0, 1'b1, d);
            if (l >= ND) chk("R10 absent device reads zero", d, 8'h00);
            else chk("R9 banked readback", d, exp_bank(l, r));
            for (int k = 0; k < ND; k++) begin
                chk("R12 dev_en", en0[k], m_en[k]);
                chk("R12 dev_base", base0[16*k +: 16], m_b0[k]);
                chk("R12 dev_irq", irq0[8*k +: 8], m_irq[k]);
            end
        end

        // R10 / R9 full sweep of every device register
        for (int l = 0; l < 6; l++) begin
            wr(0, 1'b0, 8'h07); wr(0, 1'b1, 8'(l));
            for (int j = 0; j < 8; j++) begin
                rd_reg(0, idx_set[j], d);
                chk("R9 R10 sweep", d, exp_bank(l, idx_set[j]));
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule